// File: doc/BRIEF.md
# Two-Bank SDRAM Command Timing Monitor

This block watches the command pins of a synchronous DRAM interface with two internal banks and reports every command that breaks a bank-state rule or a minimum-spacing rule. On each rising clock edge it decodes chip select, row strobe, column strobe and write enable. It also reads the auto-precharge / all-banks address bit and the bank bit. From these it keeps an open/idle state and a set of cycle counters for each bank. A copy of the programmed burst length and CAS latency is kept as well, so the monitor can work out when an auto-precharge burst ends and when its bank actually closes.

All timing limits are parameters counted in clock cycles. The outputs are registered, so they describe the command sampled at the previous rising edge. The outputs are the decoded command code, the open state of both banks, and a vector with one violation bit per rule. A violating command is still applied to the tracked state, so monitoring carries on after an error. The monitor is meant to sit beside a memory controller in simulation or in a debug build and watch the pins without driving anything.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The pins {cs_n, ras_n, cas_n, we_n} are decoded and shown on cmd_code one cycle later. The codes are: 0 deselect (cs_n high), 1 no-op (0111), 2 activate (0011), 3 read (0101), 4 write (0100), 5 precharge (0010), 6 burst stop (0110), 7 auto-refresh (0001) and 8 mode set (0000). After reset, cmd_code is 0, bank_open is 0 and viol is 0.
- R2: bank_open bit b is bank b's state. An activate to bank b sets the bit. A precharge with a10 low clears only the bank given by ba. A precharge with a10 high clears both banks.
- R3: A read or write to an idle bank sets viol bit 0. An activate to a bank that is already open sets viol bit 1.
- R4: A read or write to an open bank that comes fewer than T_RCD cycles after that bank's activate sets viol bit 2.
- R5: An activate fewer than T_RC cycles after the previous activate of the same bank sets viol bit 3. An activate fewer than T_RRD cycles after an activate of the other bank sets viol bit 4.
- R6: An activate fewer than T_RP cycles after its bank was precharged sets viol bit 5. A precharge that closes an open bank fewer than T_RAS cycles after that bank's activate sets viol bit 6.
- R7: A mode set latches the burst-length code from mode_addr[2:0] and the CAS latency from mode_addr[6:4]. The burst-length codes are 0→1, 1→2, 2→4, 3→8 and 7→full page of PAGE_COLS; any other code means 1. A latency field of 3 selects 3; any other value selects 2. After reset the burst length is 1 and the latency is 2.
- R8: A read with a10 high to an open bank closes that bank BL cycles after the command. A write with a10 high closes it BL-1+T_WR cycles after the command.
- R9: After an auto-precharge read there is a busy window of BL+CL-1 cycles; after an auto-precharge write the window is BL-1 cycles. A read, write or precharge to either bank inside that window sets viol bit 7.
- R10: A read or write with a10 high while the full-page length is selected sets viol bit 8. The access is then treated as a plain access: the bank stays open and no busy window starts.
- R11: An activate to a bank is blocked in two cases: while that bank's write auto-precharge is still pending, and fewer than T_RP cycles after the close point of that write auto-precharge. In both cases viol bit 9 is set and bit 5 is not.
- R12: A burst stop while the full-page length is not selected sets viol bit 10. With full page selected, a burst stop raises nothing.
- R13: Each violation bit is high for exactly the one cycle that reports the offending command. The command still updates the bank state.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, commands sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| a10 | input | 1 | Auto-precharge flag on read/write, all-banks flag on precharge |
| ba | input | 1 | Bank select |
| mode_addr | input | 7 | Low address pins, latched on mode set |
| cmd_code | output | 4 | Decoded command of the previous cycle |
| bank_open | output | 2 | Open state, one bit per bank |
| viol | output | 11 | One pulse bit per broken rule |

## Verification
Some properties are checked on every cycle by the assertions. A reported violation always belongs to a command that can break a rule. A tRCD report never comes together with an idle-bank report. An activate always leaves its bank open, and an all-banks precharge always leaves both banks idle. A pending auto-precharge never exists on a closed bank.

The bench scenarios are what show the exact spacing limits. They sweep each distance across its threshold, and they cover the bank close point and busy window for every burst length, latency and direction. They also separate the tDAL report from the plain tRP report, and show that auto-precharge with full page does not close the bank.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_BST   = 4'd6,
        CMD_REF   = 4'd7,
        CMD_MRS   = 4'd8
    } cmd_e;

    localparam int NVIOL      = 11;
    localparam int V_IDLE_ACC = 0;
    localparam int V_OPEN_ACT = 1;
    localparam int V_RCD      = 2;
    localparam int V_RC       = 3;
    localparam int V_RRD      = 4;
    localparam int V_RP       = 5;
    localparam int V_RAS      = 6;
    localparam int V_AP_BUSY  = 7;
    localparam int V_AP_PAGE  = 8;
    localparam int V_DAL      = 9;
    localparam int V_BST      = 10;

    localparam logic [2:0] BL_FULL_CODE = 3'd7;

    typedef struct packed {
        logic [2:0] bl_code;
        logic       cl3;
    } mode_t;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        if (cs_n) return CMD_DESEL;
        case ({ras_n, cas_n, we_n})
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            3'b110:  return CMD_BST;
            3'b001:  return CMD_REF;
            3'b000:  return CMD_MRS;
            default: return CMD_NOP;
        endcase
    endfunction

    function automatic int burst_len(input logic [2:0] code, input int page_cols);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            3'd7:    return page_cols;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [6:0] addr,
    output mode_t      mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '{bl_code: 3'd0, cl3: 1'b0};
        end else if (load) begin
            mode <= '{bl_code: addr[2:0], cl3: (addr[6:4] == 3'd3)};
        end
    end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
    parameter int CW = 4,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          do_act,
    input  logic          do_pre,
    input  logic          ap_load,
    input  logic          ap_wr_in,
    input  logic [DW-1:0] ap_delay,
    output logic          is_open,
    output logic [CW-1:0] since_act,
    output logic [CW-1:0] since_pre,
    output logic          ap_pend,
    output logic          ap_wr,
    output logic          wap_close
);
    localparam logic [CW-1:0] SAT = '1;

    logic [DW-1:0] ap_cnt;
    logic          ap_fire;
    logic          closing;

    assign ap_fire = (ap_cnt == DW'(1));
    assign closing = do_pre || (ap_fire && !ap_load);
    assign ap_pend = (ap_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open   <= 1'b0;
            since_act <= SAT;
            since_pre <= SAT;
            ap_cnt    <= '0;
            ap_wr     <= 1'b0;
            wap_close <= 1'b0;
        end else begin
            if (do_act)       is_open <= 1'b1;
            else if (closing) is_open <= 1'b0;

            if (do_act)                since_act <= CW'(1);
            else if (since_act != SAT) since_act <= since_act + CW'(1);

            if (closing)               since_pre <= CW'(1);
            else if (since_pre != SAT) since_pre <= since_pre + CW'(1);

            if (ap_load) begin
                ap_cnt <= ap_delay;
                ap_wr  <= ap_wr_in;
            end else if (do_pre) begin
                ap_cnt <= '0;
            end else if (ap_cnt != '0) begin
                ap_cnt <= ap_cnt - DW'(1);
            end

            if (do_pre)       wap_close <= 1'b0;
            else if (closing) wap_close <= ap_wr;
        end
    end

    AST_AP_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (ap_cnt != '0) |-> is_open)
        else $error("pending auto-precharge on a closed bank"); // R8

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RC      = 8,
    parameter int T_RRD     = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 5,
    parameter int T_WR      = 2,
    parameter int PAGE_COLS = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             a10,
    input  logic             ba,
    input  logic [6:0]       mode_addr,
    output logic [3:0]       cmd_code,
    output logic [1:0]       bank_open,
    output logic [NVIOL-1:0] viol
);
    localparam int NBANK = 2;
    localparam int TMAX1 = (T_RC > T_RAS) ? T_RC : T_RAS;
    localparam int TMAX2 = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TMAX3 = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int TMAX  = (TMAX3 > T_RRD) ? TMAX3 : T_RRD;
    localparam int CW    = $clog2(TMAX + 2);
    localparam int DMAX  = PAGE_COLS + T_WR + 3;
    localparam int DW    = $clog2(DMAX + 1);

    cmd_e  cmd, cmd_q;
    mode_t mode;
    logic  ba_q;

    logic [NBANK-1:0] is_open, ap_pend, ap_wr, wap_close;
    logic [NBANK-1:0] do_act, do_pre, ap_ld;
    logic [CW-1:0]    since_act [NBANK];
    logic [CW-1:0]    since_pre [NBANK];

    logic             access, ap_req, ap_ok, full;
    int               bl, cl;
    logic [DW-1:0]    ap_delay, busy_cnt;
    logic [NVIOL-1:0] v, viol_q;

    assign cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);

    sdram_mode_reg u_mode (
        .clk  (clk),
        .rst  (rst),
        .load (cmd == CMD_MRS),
        .addr (mode_addr),
        .mode (mode)
    );

    assign bl       = burst_len(mode.bl_code, PAGE_COLS);
    assign cl       = mode.cl3 ? 3 : 2;
    assign full     = (mode.bl_code == BL_FULL_CODE);
    assign access   = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign ap_req   = access && a10;
    assign ap_ok    = ap_req && !full && is_open[ba];
    assign ap_delay = (cmd == CMD_WR) ? DW'(bl - 1 + T_WR) : DW'(bl);

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            do_act[b] = (cmd == CMD_ACT) && (ba == 1'(b));
            do_pre[b] = (cmd == CMD_PRE) && (a10 || (ba == 1'(b))) && is_open[b];
            ap_ld[b]  = ap_ok && (ba == 1'(b));
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdram_bank_track #(.CW(CW), .DW(DW)) u_trk (
            .clk       (clk),
            .rst       (rst),
            .do_act    (do_act[g]),
            .do_pre    (do_pre[g]),
            .ap_load   (ap_ld[g]),
            .ap_wr_in  (cmd == CMD_WR),
            .ap_delay  (ap_delay),
            .is_open   (is_open[g]),
            .since_act (since_act[g]),
            .since_pre (since_pre[g]),
            .ap_pend   (ap_pend[g]),
            .ap_wr     (ap_wr[g]),
            .wap_close (wap_close[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= '0;
        end else if (ap_ok) begin
            busy_cnt <= (cmd == CMD_WR) ? DW'(bl - 1) : DW'(bl + cl - 1);
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - DW'(1);
        end
    end

    always_comb begin
        v = '0;
        if (access) begin
            v[V_IDLE_ACC] = !is_open[ba];
            v[V_RCD]      = is_open[ba] && (int'(since_act[ba]) < T_RCD);
        end
        if (cmd == CMD_ACT) begin
            v[V_OPEN_ACT] = is_open[ba];
            v[V_RC]       = int'(since_act[ba]) < T_RC;
            v[V_RRD]      = int'(since_act[~ba]) < T_RRD;
            v[V_DAL]      = (ap_pend[ba] && ap_wr[ba]) ||
                            (wap_close[ba] && (int'(since_pre[ba]) < T_RP));
            v[V_RP]       = !wap_close[ba] && (int'(since_pre[ba]) < T_RP);
        end
        if (access || cmd == CMD_PRE) v[V_AP_BUSY] = (busy_cnt != '0);
        if (cmd == CMD_PRE) begin
            for (int b = 0; b < NBANK; b++) begin
                if (do_pre[b] && (int'(since_act[b]) < T_RAS)) v[V_RAS] = 1'b1;
            end
        end
        v[V_AP_PAGE] = ap_req && full;
        if (cmd == CMD_BST) v[V_BST] = !full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_DESEL;
            viol_q <= '0;
            ba_q   <= 1'b0;
        end else begin
            cmd_q  <= cmd;
            viol_q <= v;
            ba_q   <= ba;
        end
    end

    assign cmd_code  = cmd_q;
    assign viol      = viol_q;
    assign bank_open = is_open;

    AST_VIOL_HAS_CMD: assert property (@(posedge clk) disable iff (rst)
        (viol_q != '0) |-> (cmd_q inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_BST}))
        else $error("violation without a checked command"); // R13
    AST_RCD_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst)
        viol_q[V_RCD] |-> !viol_q[V_IDLE_ACC])
        else $error("tRCD reported on idle bank"); // R4
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_ACT) |-> bank_open[ba_q])
        else $error("activated bank not open"); // R2
    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && a10) |=> (bank_open == '0))
        else $error("all-bank precharge left a bank open"); // R2

endmodule

// File: tb/sdram_cmd_monitor_tb_top.sv
module sdram_cmd_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 3, T_RC = 8, T_RRD = 2, T_RP = 3, T_RAS = 5, T_WR = 2;

    localparam int C_DES = 0, C_NOP = 1, C_ACT = 2, C_RD = 3, C_WR = 4,
                   C_PRE = 5, C_BST = 6, C_REF = 7, C_MRS = 8;
    localparam int B_IDLE = 1, B_OPEN = 2, B_RCD = 4, B_RC = 8, B_RRD = 16,
                   B_RP = 32, B_RAS = 64, B_BUSY = 128, B_PAGE = 256,
                   B_DAL = 512, B_BST = 1024;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0, ba = 1'b0;
    logic [6:0]  mode_addr = '0;
    logic [3:0]  cmd_code;
    logic [1:0]  bank_open;
    logic [10:0] viol;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_cmd_monitor #(.T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RP(T_RP),
                        .T_RAS(T_RAS), .T_WR(T_WR), .PAGE_COLS(256)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .a10(a10), .ba(ba), .mode_addr(mode_addr),
        .cmd_code(cmd_code), .bank_open(bank_open), .viol(viol));

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(input int c, input bit b, input bit a, input logic [6:0] ad);
        case (c)
            C_DES:   {cs_n, ras_n, cas_n, we_n} = 4'b1111;
            C_ACT:   {cs_n, ras_n, cas_n, we_n} = 4'b0011;
            C_RD:    {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            C_WR:    {cs_n, ras_n, cas_n, we_n} = 4'b0100;
            C_PRE:   {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            C_BST:   {cs_n, ras_n, cas_n, we_n} = 4'b0110;
            C_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            C_MRS:   {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
        ba = b; a10 = a; mode_addr = ad;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(C_NOP, 0, 0, '0);
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [6:0] mbits(input int blc, input int cl);
        return {3'(cl), 1'b0, 3'(blc)};
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        reset_dut();
        chk("R1 reset cmd_code", int'(cmd_code), 0);
        chk("R1 reset bank_open", int'(bank_open), 0);
        chk("R1 reset viol", int'(viol), 0);

        // R1 decode of every pin pattern
        for (int k = 0; k <= 8; k++) begin
            step(k, 1, 0, (k == C_MRS) ? mbits(0, 2) : 7'd0);
            chk("R1 decode", int'(cmd_code), k);
        end

        // R3 idle access, open activate; R13 pulse and state continue
        reset_dut();
        step(C_RD, 1, 0, '0); chk("R3 read idle", int'(viol), B_IDLE);
        step(C_WR, 0, 0, '0); chk("R3 write idle", int'(viol), B_IDLE);
        step(C_NOP, 0, 0, '0); chk("R13 pulse ends", int'(viol), 0);
        step(C_ACT, 0, 0, '0); idle(9);
        step(C_ACT, 0, 0, '0); chk("R3 act open", int'(viol), B_OPEN);
        chk("R13 state kept", int'(bank_open), 1);
        step(C_NOP, 0, 0, '0); chk("R13 pulse ends", int'(viol), 0);

        // R2 single and all-bank precharge
        reset_dut();
        step(C_ACT, 0, 0, '0); idle(1);
        step(C_ACT, 1, 0, '0); chk("R2 both open", int'(bank_open), 3);
        idle(T_RAS);
        step(C_PRE, 1, 0, '0); chk("R2 one closed", int'(bank_open), 1);
        chk("R2 legal pre", int'(viol), 0);
        step(C_PRE, 0, 1, '0); chk("R2 all closed", int'(bank_open), 0);

        // R4 tRCD sweep
        for (int d = 1; d <= 6; d++) begin
            reset_dut();
            step(C_ACT, 0, 0, '0); idle(d - 1);
            step(C_RD, 0, 0, '0);
            chk("R4 tRCD", int'(viol), (d < T_RCD) ? B_RCD : 0);
        end

        // R5 tRRD sweep
        for (int d = 1; d <= 4; d++) begin
            reset_dut();
            step(C_ACT, 0, 0, '0); idle(d - 1);
            step(C_ACT, 1, 0, '0);
            chk("R5 tRRD", int'(viol), (d < T_RRD) ? B_RRD : 0);
        end

        // R5/R6 tRAS, tRP, tRC sweep
        for (int p = 3; p <= 6; p++) begin
            for (int d = p + 1; d <= p + 4; d++) begin
                reset_dut();
                step(C_ACT, 0, 0, '0); idle(p - 1);
                step(C_PRE, 0, 0, '0);
                chk("R6 tRAS", int'(viol), (p < T_RAS) ? B_RAS : 0);
                idle(d - p - 1);
                step(C_ACT, 0, 0, '0);
                chk("R5 R6 tRC tRP", int'(viol),
                    ((d < T_RC) ? B_RC : 0) | (((d - p) < T_RP) ? B_RP : 0));
            end
        end

        // R7 R8 R9 R11 auto-precharge sweeps
        for (int blc = 0; blc <= 3; blc++) begin
            for (int cl = 2; cl <= 3; cl++) begin
                for (int wr = 0; wr <= 1; wr++) begin
                    automatic int bl = 1 << blc;
                    automatic int dly = wr ? (bl - 1 + T_WR) : bl;
                    automatic int len = wr ? (bl - 1) : (bl + cl - 1);
                    automatic int acc = wr ? C_WR : C_RD;

                    reset_dut();
                    step(C_MRS, 0, 0, mbits(blc, cl));
                    step(C_ACT, 0, 0, '0); idle(T_RCD - 1);
                    step(acc, 0, 1, '0);
                    for (int k = 1; k <= dly + 1; k++) begin
                        step(C_NOP, 0, 0, '0);
                        chk("R7 R8 close point", int'(bank_open[0]), (k < dly) ? 1 : 0);
                    end

                    for (int j = 1; j <= len + 1; j++) begin
                        reset_dut();
                        step(C_MRS, 0, 0, mbits(blc, cl));
                        step(C_ACT, 0, 0, '0); idle(T_RCD - 1);
                        step(acc, 0, 1, '0); idle(j - 1);
                        step(C_PRE, 1, 0, '0);
                        chk("R9 busy window", int'(viol), (j <= len) ? B_BUSY : 0);
                    end

                    for (int j = 1; j <= dly + T_RP + 1; j++) begin
                        automatic int e = ((T_RCD + j) < T_RC) ? B_RC : 0;
                        if (j <= dly) e |= B_OPEN | (wr ? B_DAL : 0);
                        else if ((j - dly) < T_RP) e |= wr ? B_DAL : B_RP;
                        reset_dut();
                        step(C_MRS, 0, 0, mbits(blc, cl));
                        step(C_ACT, 0, 0, '0); idle(T_RCD - 1);
                        step(acc, 0, 1, '0); idle(j - 1);
                        step(C_ACT, 0, 0, '0);
                        chk("R11 act after auto-precharge", int'(viol), e);
                    end
                end
            end
        end

        // R10 auto-precharge with full page
        reset_dut();
        step(C_MRS, 0, 0, mbits(7, 2));
        step(C_ACT, 0, 0, '0); idle(T_RCD - 1);
        step(C_RD, 0, 1, '0); chk("R10 full-page ap", int'(viol), B_PAGE);
        idle(20);
        chk("R10 bank stays open", int'(bank_open[0]), 1);
        step(C_RD, 0, 0, '0); chk("R10 no busy window", int'(viol), 0);

        // R12 burst stop legality
        step(C_BST, 0, 0, '0); chk("R12 stop full page", int'(viol), 0);
        step(C_MRS, 0, 0, mbits(2, 2));
        step(C_BST, 0, 0, '0); chk("R12 stop burst 4", int'(viol), B_BST);
        step(C_NOP, 0, 0, '0); chk("R13 pulse ends", int'(viol), 0);

        summary();
    end
endmodule